// File: doc/BRIEF.md
# Lockstep Interleaved Block Memory

This block is a word-addressed memory split into a power-of-two number of banks that always act together. A word address is divided into a bank number (its low bits) and a row number (its high bits). Every memory cycle broadcasts one row and one operation to all banks at once, so each cycle moves a whole aligned block of one word per bank. A cache refill engine is the intended client: it fetches a full line with one request and receives the words one per clock.

A read cycle runs all banks for a fixed access time. When the cycle completes, each bank's word for the selected row is captured in a per-bank read latch, and a selector streams the latched words out in ascending bank order, one per clock, with a valid strobe and a last flag. Because the words sit in the latches, the banks are free again as soon as the access time has elapsed, and the next cycle may start while the previous block is still being streamed. A write goes the other way. The client fills per-bank write latches one word at a time, addressed by bank number, and then issues a commit with a row. The commit stores every latch into that row of its bank in a single cycle. A commit issued before every latch holds a word is refused and reported.

Top module: `lockstep_mem`

## Requirements
- R1: A word address splits into bank = address bits [BANK_W-1:0] and row = address bits [ADDR_W-1:BANK_W]. A load uses only the bank field of `ld_addr`. A read or a commit uses only the row field of `rd_addr` or `cm_addr`.
- R2: After reset, `busy`, `out_valid` and `commit_err` are 0 and no write latch counts as loaded, so the first commit is refused.
- R3: An accepted read or commit raises `busy` on the next edge, and `busy` stays high for exactly ACC_CYC cycles.
- R4: A read accepted on edge E produces NUM_BANKS words. `out_valid` is high after edges E+ACC_CYC through E+ACC_CYC+NUM_BANKS-1. In the cycle after edge E+ACC_CYC+i, `out_bank` equals i and `out_data` is the word stored at that row of bank i. No word appears at any other time.
- R5: `out_last` is high exactly on the word with `out_bank` = NUM_BANKS-1.
- R6: A `rd_start` or `wr_commit` seen while `busy` is high is ignored. It produces no words, no write and no `commit_err`.
- R7: A new read may be accepted in the first cycle `busy` is low, while the previous block is still being streamed. Both blocks come out whole and in order.
- R8: After a word has been loaded into every write latch, a commit writes each latch into the given row of its bank in one cycle. This raises `busy` and does not raise `commit_err`. The commit leaves every latch marked empty.
- R9: A commit issued while idle but before every latch has been loaded is ignored. It leaves memory and the loaded latches unchanged, keeps `busy` low, and raises `commit_err` for exactly the following cycle.
- R10: A load presented while a write cycle is in progress has no effect on the data that cycle stores.
- R11: If `rd_start` and `wr_commit` arrive together while idle, the read is accepted and the commit is ignored without `commit_err`. The write latches stay loaded for a later commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Request a block read |
| rd_addr | input | ADDR_W | Word address of the read; only the row field is used |
| ld_en | input | 1 | Load one word into a write latch |
| ld_addr | input | ADDR_W | Word address of the load; only the bank field is used |
| ld_data | input | DATA_W | Word to load |
| wr_commit | input | 1 | Write all latches into one row |
| cm_addr | input | ADDR_W | Word address of the commit; only the row field is used |
| busy | output | 1 | A bank cycle is in progress |
| commit_err | output | 1 | A commit was refused because a latch was empty |
| out_valid | output | 1 | A read word is on out_data |
| out_last | output | 1 | The current word is the final word of its block |
| out_bank | output | BANK_W | Bank the current word came from |
| out_data | output | DATA_W | Read word |

## Verification
The checker assumes that ACC_CYC is at least NUM_BANKS-1, so that a block captured at the end of a cycle never overtakes one still being streamed. It also assumes that a commit request lasts a single cycle, which makes each `commit_err` pulse traceable to one idle commit. The bench keeps to both. It drives each request for exactly one cycle and issues back-to-back reads only at the first idle cycle. It exercises the overlap of a new read with an active stream and sends requests during busy cycles. Its scoreboard predicts the exact cycle and value of every streamed word from the stored patterns.

// File: rtl/lkmem_pkg.sv
package lkmem_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // width of a field able to index n items (at least one bit)
    function automatic int unsigned idx_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lkmem_bank.sv
module lkmem_bank #(
    parameter int DATA_W = 16,
    parameter int ROW_W  = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[row] <= wdata;
    end

    assign rdata = mem[row];

endmodule

// File: rtl/lkmem_seq.sv
module lkmem_seq
    import lkmem_pkg::*;
#(
    parameter int ACC_CYC = 4,
    parameter int ROW_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_start,
    input  logic             wr_commit,
    input  logic             lat_full,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [ROW_W-1:0] cm_row,
    output logic             busy,
    output op_e              op,
    output logic [ROW_W-1:0] row,
    output logic             done,
    output logic             accept_wr,
    output logic             commit_err
);
    localparam int CNT_W = idx_width(ACC_CYC);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    op_e              op_q;
    logic [ROW_W-1:0] row_q;
    logic             err_q;

    logic rd_go, wr_try, wr_go;

    always_comb begin
        rd_go  = rd_start && !busy_q;
        wr_try = wr_commit && !busy_q && !rd_start;
        wr_go  = wr_try && lat_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            op_q   <= OP_READ;
            row_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= wr_try && !lat_full;
            if (rd_go || wr_go) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(ACC_CYC - 1);
                op_q   <= rd_go ? OP_READ : OP_WRITE;
                row_q  <= rd_go ? rd_row : cm_row;
            end else if (busy_q && cnt_q == '0) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy       = busy_q;
    assign op         = op_q;
    assign row        = row_q;
    assign done       = busy_q && (cnt_q == '0);
    assign accept_wr  = wr_go;
    assign commit_err = err_q;

endmodule

// File: rtl/lkmem_wlat.sv
module lkmem_wlat #(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 16,
    parameter int BANK_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_block,
    input  logic [BANK_W-1:0] ld_sel,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              clear,
    output logic              full,
    output logic [DATA_W-1:0] lat [NUM_BANKS]
);
    logic [NUM_BANKS-1:0] loaded_q;
    logic                 ld_ok;

    assign ld_ok = ld_en && !ld_block;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lat
        always_ff @(posedge clk) begin
            if (rst) begin
                lat[b]      <= '0;
                loaded_q[b] <= 1'b0;
            end else if (clear) begin
                loaded_q[b] <= 1'b0;
            end else if (ld_ok && ld_sel == BANK_W'(b)) begin
                lat[b]      <= ld_data;
                loaded_q[b] <= 1'b1;
            end
        end
    end

    assign full = &loaded_q;

endmodule

// File: rtl/lkmem_drain.sv
module lkmem_drain #(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 16,
    parameter int BANK_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] in_words [NUM_BANKS],
    output logic              out_valid,
    output logic              out_last,
    output logic [BANK_W-1:0] out_bank,
    output logic [DATA_W-1:0] out_data
);
    localparam logic [BANK_W-1:0] LAST_IDX = BANK_W'(NUM_BANKS - 1);

    logic [DATA_W-1:0] words_q [NUM_BANKS];
    logic              active_q;
    logic [BANK_W-1:0] idx_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst)          words_q[b] <= '0;
            else if (capture) words_q[b] <= in_words[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (capture) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (active_q) begin
            if (idx_q == LAST_IDX) active_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign out_valid = active_q;
    assign out_last  = active_q && (idx_q == LAST_IDX);
    assign out_bank  = idx_q;
    assign out_data  = words_q[idx_q];

endmodule

// File: rtl/lockstep_mem.sv
module lockstep_mem
    import lkmem_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int ACC_CYC   = 4,
    localparam int BANK_W   = idx_width(NUM_BANKS),
    localparam int ROW_W    = ADDR_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              wr_commit,
    input  logic [ADDR_W-1:0] cm_addr,
    output logic              busy,
    output logic              commit_err,
    output logic              out_valid,
    output logic              out_last,
    output logic [BANK_W-1:0] out_bank,
    output logic [DATA_W-1:0] out_data
);
    op_e               op;
    logic [ROW_W-1:0]  row;
    logic              done;
    logic              accept_wr;
    logic              lat_full;
    logic              bank_we;
    logic              capture;
    logic              ld_block;
    logic [DATA_W-1:0] wlat  [NUM_BANKS];
    logic [DATA_W-1:0] rword [NUM_BANKS];

    // fields that are not used by the given request kind
    logic unused_fields;
    assign unused_fields = ^{rd_addr[BANK_W-1:0], cm_addr[BANK_W-1:0],
                             ld_addr[ADDR_W-1:BANK_W]};

    lkmem_seq #(
        .ACC_CYC (ACC_CYC),
        .ROW_W   (ROW_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rd_start   (rd_start),
        .wr_commit  (wr_commit),
        .lat_full   (lat_full),
        .rd_row     (rd_addr[ADDR_W-1:BANK_W]),
        .cm_row     (cm_addr[ADDR_W-1:BANK_W]),
        .busy       (busy),
        .op         (op),
        .row        (row),
        .done       (done),
        .accept_wr  (accept_wr),
        .commit_err (commit_err)
    );

    assign bank_we  = done && (op == OP_WRITE);
    assign capture  = done && (op == OP_READ);
    assign ld_block = (busy && op == OP_WRITE) || accept_wr;

    lkmem_wlat #(
        .NUM_BANKS (NUM_BANKS),
        .DATA_W    (DATA_W),
        .BANK_W    (BANK_W)
    ) u_wlat (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_en),
        .ld_block (ld_block),
        .ld_sel   (ld_addr[BANK_W-1:0]),
        .ld_data  (ld_data),
        .clear    (accept_wr),
        .full     (lat_full),
        .lat      (wlat)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        lkmem_bank #(
            .DATA_W (DATA_W),
            .ROW_W  (ROW_W)
        ) u_bank (
            .clk   (clk),
            .we    (bank_we),
            .row   (row),
            .wdata (wlat[b]),
            .rdata (rword[b])
        );
    end

    lkmem_drain #(
        .NUM_BANKS (NUM_BANKS),
        .DATA_W    (DATA_W),
        .BANK_W    (BANK_W)
    ) u_drain (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .in_words  (rword),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_bank  (out_bank),
        .out_data  (out_data)
    );

endmodule

// File: rtl/lockstep_mem_chk.sv
module lockstep_mem_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ACC_CYC   = 4,
    parameter int BANK_W    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_start,
    input logic              wr_commit,
    input logic              busy,
    input logic              commit_err,
    input logic              out_valid,
    input logic              out_last,
    input logic [BANK_W-1:0] out_bank
);
    int run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_q == ACC_CYC)
        else $error("busy window length wrong");

    assert_bank_step_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_last |=> out_valid && out_bank == $past(out_bank) + 1'b1)
        else $error("stream order broken");

    assert_first_bank_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_bank == '0)
        else $error("stream does not start at bank 0");

    assert_last_flag_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (out_bank == BANK_W'(NUM_BANKS - 1))))
        else $error("last flag misplaced");

    assert_start_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(rd_start || wr_commit))
        else $error("busy rose without a request");

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        commit_err |-> $past(wr_commit && !busy && !rd_start))
        else $error("commit error without an idle commit");

endmodule

bind lockstep_mem lockstep_mem_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ACC_CYC   (ACC_CYC),
    .BANK_W    (BANK_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_start   (rd_start),
    .wr_commit  (wr_commit),
    .busy       (busy),
    .commit_err (commit_err),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .out_bank   (out_bank)
);

// File: tb/lockstep_mem_tb.sv
module lockstep_mem_tb;
    localparam int K      = 4;
    localparam int AW     = 6;
    localparam int DW     = 16;
    localparam int ACC    = 4;
    localparam int BW     = 2;
    localparam int ROWS   = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          rd_start, ld_en, wr_commit;
    logic [AW-1:0] rd_addr, ld_addr, cm_addr;
    logic [DW-1:0] ld_data;
    logic          busy, commit_err, out_valid, out_last;
    logic [BW-1:0] out_bank;
    logic [DW-1:0] out_data;

    always #2 clk = ~clk;

    lockstep_mem #(
        .NUM_BANKS (K),
        .ADDR_W    (AW),
        .DATA_W    (DW),
        .ACC_CYC   (ACC)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .rd_start   (rd_start),
        .rd_addr    (rd_addr),
        .ld_en      (ld_en),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .wr_commit  (wr_commit),
        .cm_addr    (cm_addr),
        .busy       (busy),
        .commit_err (commit_err),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .out_bank   (out_bank),
        .out_data   (out_data)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 0;

    logic [DW-1:0] exp_mem [K][ROWS];

    typedef struct {
        int            due;
        int            bank;
        logic [DW-1:0] data;
    } exp_t;
    exp_t q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] pat(int s, int b, int r);
        return DW'((s << 8) | (b << 4) | r);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // scoreboard for streamed words (R4, R5, R6, R7)
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                check(out_valid == 1'b1, "R4", "valid", out_valid, 1);
                check(int'(out_bank) == q[0].bank, "R4", "bank order", out_bank, q[0].bank);
                check(out_data == q[0].data, "R4", "word", out_data, q[0].data);
                check(out_last == (q[0].bank == K - 1), "R5", "last flag", out_last, q[0].bank == K - 1);
                void'(q.pop_front());
            end else if (out_valid) begin
                check(1'b0, "R6", "unexpected word", out_valid, 0);
            end
        end
    end

    // all tasks start and end at a falling edge
    task automatic load(int b, int junk, logic [DW-1:0] d);
        ld_en = 1'b1; ld_addr = {4'(junk), 2'(b)}; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic push_read(int r);
        for (int b = 0; b < K; b++) begin
            exp_t e;
            e.due = cyc + ACC + b; e.bank = b; e.data = exp_mem[b][r];
            q.push_back(e);
        end
    endtask

    task automatic issue_read(int r, int junk);
        rd_start = 1'b1; rd_addr = {4'(r), 2'(junk)};
        @(negedge clk);
        rd_start = 1'b0;
        push_read(r);
    endtask

    task automatic commit(int r, int junk);
        wr_commit = 1'b1; cm_addr = {4'(r), 2'(junk)};
        @(negedge clk);
        wr_commit = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic drain();
        repeat (K + 2) @(negedge clk);
        check(q.size() == 0, "R4", "words outstanding", q.size(), 0);
    endtask

    task automatic write_row(int r, int s, bit glitch);
        for (int b = 0; b < K; b++) load(b, (r + b) & 15, pat(s, b, r));
        commit(r, r & 3);
        check(commit_err == 1'b0, "R8", "commit flagged", commit_err, 0);
        for (int i = 0; i < ACC; i++) begin
            check(busy == 1'b1, "R3", "busy in window", busy, 1);
            if (glitch && i == 1) begin
                ld_en = 1'b1; ld_addr = '0; ld_data = 16'hDEAD;
            end
            @(negedge clk);
            ld_en = 1'b0;
        end
        check(busy == 1'b0, "R3", "busy after window", busy, 0);
        for (int b = 0; b < K; b++) exp_mem[b][r] = pat(s, b, r);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", cyc, 0);
        summary();
    end

    initial begin
        rst = 1'b1; rd_start = 0; ld_en = 0; wr_commit = 0;
        rd_addr = '0; ld_addr = '0; cm_addr = '0; ld_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0, "R2", "busy after reset", busy, 0);
        check(out_valid == 0, "R2", "valid after reset", out_valid, 0);
        check(commit_err == 0, "R2", "err after reset", commit_err, 0);

        // R2/R9: latches empty after reset, so commit is refused
        commit(0, 0);
        check(commit_err == 1, "R2", "commit on empty latches", commit_err, 1);
        check(busy == 0, "R9", "busy on refused commit", busy, 0);
        @(negedge clk);
        check(commit_err == 0, "R9", "err pulse width", commit_err, 0);

        // R1/R8/R10: fill every row (garbage load during the first write)
        for (int r = 0; r < ROWS; r++) write_row(r, 1, r == 0);

        // R7: reads chained at the first idle cycle, R1 junk low bits
        for (int r = 0; r < ROWS; r++) begin
            issue_read(r, (r * 3) & 3);
            wait_idle();
        end
        drain();

        // R9: three of four latches loaded, commit refused
        for (int b = 0; b < K - 1; b++) load(b, 9, pat(3, b, 5));
        commit(5, 1);
        check(commit_err == 1, "R9", "partial commit flagged", commit_err, 1);
        check(busy == 0, "R9", "partial commit busy", busy, 0);
        @(negedge clk);
        check(commit_err == 0, "R9", "err pulse width", commit_err, 0);
        issue_read(5, 0); wait_idle(); drain();
        load(K - 1, 2, pat(3, K - 1, 5));
        commit(5, 2);
        check(busy == 1, "R9", "latches kept after refusal", busy, 1);
        wait_idle();
        for (int b = 0; b < K; b++) exp_mem[b][5] = pat(3, b, 5);
        issue_read(5, 3); wait_idle(); drain();

        // R11: read wins over simultaneous commit
        for (int b = 0; b < K; b++) load(b, 0, pat(9, b, 9));
        rd_start = 1; rd_addr = {4'd2, 2'd1}; wr_commit = 1; cm_addr = {4'd9, 2'd0};
        @(negedge clk);
        rd_start = 0; wr_commit = 0;
        push_read(2);
        check(commit_err == 0, "R11", "err on collision", commit_err, 0);
        check(busy == 1, "R11", "read accepted", busy, 1);
        wait_idle(); drain();
        issue_read(9, 0); wait_idle(); drain();
        commit(9, 1);
        check(busy == 1, "R11", "latches still loaded", busy, 1);
        wait_idle();
        for (int b = 0; b < K; b++) exp_mem[b][9] = pat(9, b, 9);
        issue_read(9, 2); wait_idle(); drain();

        // R6: requests during busy are dropped
        issue_read(3, 0);
        rd_start = 1; rd_addr = {4'd4, 2'd0}; wr_commit = 1; cm_addr = {4'd4, 2'd0};
        @(negedge clk);
        rd_start = 0; wr_commit = 0;
        check(commit_err == 0, "R6", "err on busy commit", commit_err, 0);
        wait_idle(); drain();
        check(busy == 0, "R6", "no extra cycle", busy, 0);

        summary();
    end

endmodule